// File: doc/BRIEF.md
# USB IN Endpoint Response Controller

This block decides how each IN endpoint of a USB device answers an IN token from the host. For the addressed endpoint it picks one of three replies: a data packet taken from that endpoint's FIFO, a forced zero-length packet, or NAK. The block is registered, so the reply appears one cycle after the token strobe. Packet serialisation and FIFO storage sit outside the block. The block only reads a per-endpoint FIFO-empty flag and returns a reply code.

Each endpoint has three control bits that software writes and reads back:
- an interrupt-pending bit, which gates interrupt endpoints;
- a force-zero-length bit, which overrides the FIFO. On the control endpoint, hardware clears it once the host acknowledges the packet. On other endpoints, only software clears it.
- a command-complete bit, which tracks control transfers. A setup phase clears it, and a status phase or a software write sets it.

Endpoint kind is a static strap per endpoint: control or not, interrupt or not. A control strap takes precedence over the interrupt strap.

Top module: `usb_in_resp_ctrl`

## Requirements
- R1: After reset the pending, force-zero and command-complete bits of every endpoint read 0, and `rsp_sel` reads 0 (no reply).
- R2: `rsp_sel` carries the reply for an IN token in the cycle after `in_tok` is high, coded 1 = data, 2 = zero-length, 3 = NAK. In any cycle not following a token it reads 0.
- R3: When the addressed endpoint's force-zero bit is set, the reply is zero-length (2), whatever the FIFO state and pending bit.
- R4: On an interrupt, non-control endpoint whose pending bit is clear and whose force-zero bit is clear, the reply is NAK (3), even with data in the FIFO.
- R5: On an interrupt endpoint with the pending bit set and force-zero clear, the reply is data (1) when `fifo_empty` for that endpoint is 0, and NAK (3) when it is 1.
- R6: On a non-interrupt endpoint, or on a control endpoint, with force-zero clear, the reply is data (1) when its FIFO is not empty and NAK (3) when it is empty.
- R7: A software write (`sw_wr`) selects a bit with `sw_bit`: 0 = pending, 1 = force-zero, 2 = command-complete. `sw_val` is the value written. The new value is visible on the readback in the next cycle, and the pending bit can be both set and cleared this way.
- R8: On a non-control endpoint the force-zero bit is set and cleared only by software. A host ACK does not clear it.
- R9: On a control endpoint a software write of 0 to force-zero is ignored. The bit is cleared when `host_ack` arrives for that endpoint while the bit is set.
- R10: A `setup_tok` for an endpoint clears its command-complete bit, and a `status_done` sets it. Once set, it stays set until the next setup for that endpoint.
- R11: A software write of 1 sets command-complete, and a software write of 0 to it is ignored. A setup clear in the same cycle as any set wins, leaving the bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_ctrl_mask | input | NUM_EP | Per-endpoint strap: 1 = control endpoint |
| ep_intr_mask | input | NUM_EP | Per-endpoint strap: 1 = interrupt endpoint |
| fifo_empty | input | NUM_EP | Per-endpoint FIFO empty flag |
| in_tok | input | 1 | IN token strobe |
| tok_ep | input | EPW | Endpoint addressed by the IN token |
| host_ack | input | 1 | Host ACK received for the last packet |
| ack_ep | input | EPW | Endpoint the ACK belongs to |
| setup_tok | input | 1 | Setup phase strobe |
| status_done | input | 1 | Status phase strobe |
| ctl_ep | input | EPW | Endpoint addressed by setup or status strobes |
| sw_wr | input | 1 | Software register write strobe |
| sw_ep | input | EPW | Endpoint targeted by the write |
| sw_bit | input | 2 | Bit select: 0 pending, 1 force-zero, 2 command-complete |
| sw_val | input | 1 | Value written |
| rsp_sel | output | 2 | Reply code: 0 none, 1 data, 2 zero-length, 3 NAK |
| rd_int | output | NUM_EP | Pending bit readback |
| rd_txz | output | NUM_EP | Force-zero bit readback |
| rd_ccomp | output | NUM_EP | Command-complete bit readback |

## Verification
The bit state can go wrong in two ways.

- **A lost or spurious clear of force-zero or command-complete.** This shows on the readback one cycle after the event that should or should not have touched the bit. It then changes the reply to the next IN token, for example data where a zero-length packet was due.
- **A wrong pending bit.** This shows as NAK against data on the very next token to that interrupt endpoint.

The checks therefore pair each control event with an immediate readback and a following token. They also cover the ignored writes and ACKs, where the risk is a bit that changes when it should hold.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_DATA = 2'd1,
        RSP_ZLP  = 2'd2,
        RSP_NAK  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        SWB_INT   = 2'd0,
        SWB_TXZ   = 2'd1,
        SWB_CCOMP = 2'd2,
        SWB_RSVD  = 2'd3
    } swbit_e;

    typedef struct packed {
        logic int_en;
        logic txz;
        logic ccomp;
    } ep_bits_t;

endpackage

// File: rtl/usb_in_ep_bits.sv
module usb_in_ep_bits
    import usb_in_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_ctrl,
    input  logic       sw_hit,
    input  logic [1:0] sw_bit,
    input  logic       sw_val,
    input  logic       ack_hit,
    input  logic       setup_hit,
    input  logic       status_hit,
    output ep_bits_t   bits_q
);

    ep_bits_t bits_d;
    ep_bits_t st_q;

    always_comb begin
        bits_d = st_q;

        // pending bit: software only
        if (sw_hit && sw_bit == SWB_INT) begin
            bits_d.int_en = sw_val;
        end

        // force-zero: hardware clear on control endpoint after host ACK
        if (is_ctrl && ack_hit && st_q.txz) begin
            bits_d.txz = 1'b0;
        end
        if (sw_hit && sw_bit == SWB_TXZ) begin
            if (sw_val) begin
                bits_d.txz = 1'b1;
            end else if (!is_ctrl) begin
                bits_d.txz = 1'b0;
            end
        end

        // command-complete: sets first, setup clear has the last word
        if (status_hit || (sw_hit && sw_bit == SWB_CCOMP && sw_val)) begin
            bits_d.ccomp = 1'b1;
        end
        if (setup_hit) begin
            bits_d.ccomp = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= bits_d;
        end
    end

    assign bits_q = st_q;

endmodule

// File: rtl/usb_in_resp_pick.sv
module usb_in_resp_pick
    import usb_in_pkg::*;
(
    input  logic tok,
    input  logic is_ctrl,
    input  logic is_intr,
    input  logic int_en,
    input  logic txz,
    input  logic empty,
    output rsp_e rsp
);

    always_comb begin
        if (!tok) begin
            rsp = RSP_NONE;
        end else if (txz) begin
            rsp = RSP_ZLP;
        end else if (is_intr && !is_ctrl && !int_en) begin
            rsp = RSP_NAK;
        end else if (empty) begin
            rsp = RSP_NAK;
        end else begin
            rsp = RSP_DATA;
        end
    end

endmodule

// File: rtl/usb_in_resp_ctrl.sv
module usb_in_resp_ctrl
    import usb_in_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] ep_ctrl_mask,
    input  logic [NUM_EP-1:0] ep_intr_mask,
    input  logic [NUM_EP-1:0] fifo_empty,
    input  logic              in_tok,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              host_ack,
    input  logic [EPW-1:0]    ack_ep,
    input  logic              setup_tok,
    input  logic              status_done,
    input  logic [EPW-1:0]    ctl_ep,
    input  logic              sw_wr,
    input  logic [EPW-1:0]    sw_ep,
    input  logic [1:0]        sw_bit,
    input  logic              sw_val,
    output logic [1:0]        rsp_sel,
    output logic [NUM_EP-1:0] rd_int,
    output logic [NUM_EP-1:0] rd_txz,
    output logic [NUM_EP-1:0] rd_ccomp
);

    typedef struct packed {
        rsp_e rsp;
    } top_st_t;

    ep_bits_t ep_bits [NUM_EP];

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic sw_hit_g;
        logic ack_hit_g;
        logic setup_hit_g;
        logic status_hit_g;

        assign sw_hit_g     = sw_wr && (sw_ep == EPW'(g));
        assign ack_hit_g    = host_ack && (ack_ep == EPW'(g));
        assign setup_hit_g  = setup_tok && (ctl_ep == EPW'(g));
        assign status_hit_g = status_done && (ctl_ep == EPW'(g));

        usb_in_ep_bits u_bits (
            .clk        (clk),
            .rst_n      (rst_n),
            .is_ctrl    (ep_ctrl_mask[g]),
            .sw_hit     (sw_hit_g),
            .sw_bit     (sw_bit),
            .sw_val     (sw_val),
            .ack_hit    (ack_hit_g),
            .setup_hit  (setup_hit_g),
            .status_hit (status_hit_g),
            .bits_q     (ep_bits[g])
        );

        assign rd_int[g]   = ep_bits[g].int_en;
        assign rd_txz[g]   = ep_bits[g].txz;
        assign rd_ccomp[g] = ep_bits[g].ccomp;
    end

    rsp_e    rsp_now;
    top_st_t st_d;
    top_st_t st_q;

    usb_in_resp_pick u_pick (
        .tok     (in_tok),
        .is_ctrl (ep_ctrl_mask[tok_ep]),
        .is_intr (ep_intr_mask[tok_ep]),
        .int_en  (rd_int[tok_ep]),
        .txz     (rd_txz[tok_ep]),
        .empty   (fifo_empty[tok_ep]),
        .rsp     (rsp_now)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rsp = rsp_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rsp: RSP_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_sel = st_q.rsp;

endmodule

// File: rtl/usb_in_resp_chk.sv
module usb_in_resp_chk #(
    parameter int NUM_EP = 4,
    parameter int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EP-1:0] ep_ctrl_mask,
    input logic [NUM_EP-1:0] ep_intr_mask,
    input logic              in_tok,
    input logic [EPW-1:0]    tok_ep,
    input logic              host_ack,
    input logic [EPW-1:0]    ack_ep,
    input logic              setup_tok,
    input logic [EPW-1:0]    ctl_ep,
    input logic              sw_wr,
    input logic [EPW-1:0]    sw_ep,
    input logic [1:0]        sw_bit,
    input logic              sw_val,
    input logic [1:0]        rsp_sel,
    input logic [NUM_EP-1:0] rd_int,
    input logic [NUM_EP-1:0] rd_txz,
    input logic [NUM_EP-1:0] rd_ccomp
);

    // R2
    idle_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tok |=> rsp_sel == 2'd0);

    // R3
    zlp_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tok && rd_txz[tok_ep]) |=> rsp_sel == 2'd2);

    // R4
    intr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tok && ep_intr_mask[tok_ep] && !ep_ctrl_mask[tok_ep]
         && !rd_int[tok_ep] && !rd_txz[tok_ep]) |=> rsp_sel == 2'd3);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_chk
        // R8
        txz_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ep_ctrl_mask[g] && rd_txz[g]
             && !(sw_wr && sw_ep == EPW'(g) && sw_bit == 2'd1 && !sw_val))
            |=> rd_txz[g]);

        // R9
        txz_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ep_ctrl_mask[g] && rd_txz[g] && !(host_ack && ack_ep == EPW'(g)))
            |=> rd_txz[g]);

        // R10
        ccomp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_ccomp[g] && !(setup_tok && ctl_ep == EPW'(g)))
            |=> rd_ccomp[g]);

        // R11
        ccomp_setup_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (setup_tok && ctl_ep == EPW'(g)) |=> !rd_ccomp[g]);
    end

endmodule

bind usb_in_resp_ctrl usb_in_resp_chk #(.NUM_EP(NUM_EP), .EPW(EPW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ep_ctrl_mask (ep_ctrl_mask),
    .ep_intr_mask (ep_intr_mask),
    .in_tok       (in_tok),
    .tok_ep       (tok_ep),
    .host_ack     (host_ack),
    .ack_ep       (ack_ep),
    .setup_tok    (setup_tok),
    .ctl_ep       (ctl_ep),
    .sw_wr        (sw_wr),
    .sw_ep        (sw_ep),
    .sw_bit       (sw_bit),
    .sw_val       (sw_val),
    .rsp_sel      (rsp_sel),
    .rd_int       (rd_int),
    .rd_txz       (rd_txz),
    .rd_ccomp     (rd_ccomp)
);

// File: tb/usb_in_resp_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_in_resp_ctrl_tb_top;

    localparam int NUM_EP = 4;
    localparam int EPW    = 2;
    localparam int R_NONE = 0, R_DATA = 1, R_ZLP = 2, R_NAK = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_EP-1:0] ep_ctrl_mask = 4'b0001;
    logic [NUM_EP-1:0] ep_intr_mask = 4'b0100;
    logic [NUM_EP-1:0] fifo_empty = '0;
    logic              in_tok = 1'b0;
    logic [EPW-1:0]    tok_ep = '0;
    logic              host_ack = 1'b0;
    logic [EPW-1:0]    ack_ep = '0;
    logic              setup_tok = 1'b0;
    logic              status_done = 1'b0;
    logic [EPW-1:0]    ctl_ep = '0;
    logic              sw_wr = 1'b0;
    logic [EPW-1:0]    sw_ep = '0;
    logic [1:0]        sw_bit = '0;
    logic              sw_val = 1'b0;
    logic [1:0]        rsp_sel;
    logic [NUM_EP-1:0] rd_int;
    logic [NUM_EP-1:0] rd_txz;
    logic [NUM_EP-1:0] rd_ccomp;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    usb_in_resp_ctrl #(.NUM_EP(NUM_EP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ep_ctrl_mask(ep_ctrl_mask), .ep_intr_mask(ep_intr_mask),
        .fifo_empty(fifo_empty),
        .in_tok(in_tok), .tok_ep(tok_ep),
        .host_ack(host_ack), .ack_ep(ack_ep),
        .setup_tok(setup_tok), .status_done(status_done), .ctl_ep(ctl_ep),
        .sw_wr(sw_wr), .sw_ep(sw_ep), .sw_bit(sw_bit), .sw_val(sw_val),
        .rsp_sel(rsp_sel), .rd_int(rd_int), .rd_txz(rd_txz), .rd_ccomp(rd_ccomp)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic token(int ep, int exp, string req);
        in_tok = 1'b1; tok_ep = EPW'(ep);
        @(negedge clk);
        in_tok = 1'b0;
        check(req, int'(rsp_sel), exp);
    endtask

    task automatic swrite(int ep, int b, bit v);
        sw_wr = 1'b1; sw_ep = EPW'(ep); sw_bit = 2'(b); sw_val = v;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic ack(int ep);
        host_ack = 1'b1; ack_ep = EPW'(ep);
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rsp", int'(rsp_sel), R_NONE);
        check("R1 int", int'(rd_int), 0);
        check("R1 txz", int'(rd_txz), 0);
        check("R1 ccomp", int'(rd_ccomp), 0);
    endtask

    task automatic t_plain();
        fifo_empty = 4'b0000;
        token(1, R_DATA, "R6 bulk data");
        fifo_empty[1] = 1'b1;
        token(1, R_NAK, "R6 bulk empty");
        fifo_empty[1] = 1'b0;
        token(0, R_DATA, "R6 control data");
        @(negedge clk);
        check("R2 idle cycle", int'(rsp_sel), R_NONE);
    endtask

    task automatic t_intr();
        token(2, R_NAK, "R4 int clear nak");
        swrite(2, 0, 1'b1);
        check("R7 int set", int'(rd_int[2]), 1);
        token(2, R_DATA, "R5 int set data");
        fifo_empty[2] = 1'b1;
        token(2, R_NAK, "R5 int set empty");
        fifo_empty[2] = 1'b0;
        swrite(2, 0, 1'b0);
        check("R7 int clear", int'(rd_int[2]), 0);
        token(2, R_NAK, "R4 after clear");
    endtask

    task automatic t_txz_bulk();
        swrite(1, 1, 1'b1);
        check("R7 txz set", int'(rd_txz[1]), 1);
        token(1, R_ZLP, "R3 zlp over data");
        ack(1);
        check("R8 ack ignored", int'(rd_txz[1]), 1);
        token(1, R_ZLP, "R3 zlp repeat");
        swrite(1, 1, 1'b0);
        check("R8 sw clear", int'(rd_txz[1]), 0);
        token(1, R_DATA, "R8 data again");
    endtask

    task automatic t_txz_ctrl();
        swrite(0, 1, 1'b1);
        token(0, R_ZLP, "R3 ctrl zlp");
        swrite(0, 1, 1'b0);
        check("R9 sw clear ignored", int'(rd_txz[0]), 1);
        ack(1);
        check("R9 other ep ack", int'(rd_txz[0]), 1);
        ack(0);
        check("R9 ack clears", int'(rd_txz[0]), 0);
        token(0, R_DATA, "R9 data after clear");
    endtask

    task automatic t_ccomp();
        ctl_ep = 2'd0;
        status_done = 1'b1; @(negedge clk); status_done = 1'b0;
        check("R10 status sets", int'(rd_ccomp[0]), 1);
        repeat (3) @(negedge clk);
        check("R10 holds", int'(rd_ccomp[0]), 1);
        setup_tok = 1'b1; @(negedge clk); setup_tok = 1'b0;
        check("R10 setup clears", int'(rd_ccomp[0]), 0);
        swrite(0, 2, 1'b1);
        check("R11 sw set", int'(rd_ccomp[0]), 1);
        swrite(0, 2, 1'b0);
        check("R11 sw clear ignored", int'(rd_ccomp[0]), 1);
        setup_tok = 1'b1; status_done = 1'b1;
        @(negedge clk);
        setup_tok = 1'b0; status_done = 1'b0;
        check("R11 setup wins", int'(rd_ccomp[0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_plain();
        t_intr();
        t_txz_bulk();
        t_txz_ctrl();
        t_ccomp();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule